// File: doc/BRIEF.md
# Register-Paced Serial Flash Write Sequencer

This block drives one write frame toward a serial flash device. Each data beat is started by a write to a transmit data register, not by a bus access to a mapped memory window. Software first gives the instruction code, the start address, whether the frame carries an address phase, and the width and DDR settings. It then pulses the frame start. The block asserts chip select and shifts out the instruction and then the address. After that it waits for data.

Each accepted write to the data register becomes one data beat on the serial lines. A beat is a halfword when an octal width is chosen with DDR enabled, and a byte otherwise. The frame stays open between writes for as long as needed. Software watches an empty flag to know when the next value may be written. It closes the frame with a last-transfer command, and chip select is released once the final beat has left the shifter.

This mode only writes. A read request is answered with a one-cycle reject pulse and has no other effect. Data that does not follow on from the previous address needs a new frame, which software opens after closing the current one.

Top module: `smw_writer`

## Requirements
- R1: After reset `cs_n` is 1, `sio_en` is 0, `tx_empty` is 1 and `rd_reject` is 0.
- R2: A `frame_start` pulse while no frame is open drives `cs_n` low and shifts the 8-bit `frame_instr` out most significant bit first. Each `sio_en` cycle carries LANES bits on `sio`, with the upper bits first.
- R3: When `frame_addr_en` was 1 at frame start, the ADDR_W bits of `frame_addr` follow the instruction, most significant bit first. When it was 0, no address bits are sent.
- R4: Each accepted data write produces exactly one beat. The beat is the 16 bits `txd_data[15:0]`, most significant bit first, when `width_mode` was 3, 4 or 5 (the octal settings) and `ddr_en` was 1 at frame start. In every other case the beat is the 8 bits `txd_data[7:0]`, most significant bit first.
- R5: `tx_empty` goes to 0 in the cycle after an accepted write and returns to 1 once the shifter has taken the value. A write is dropped when the holding register is full, when no frame is open, or after a last-transfer command.
- R6: While a frame is open, `cs_n` stays 0 between data writes for any length of idle gap. A `frame_start` pulse during an open frame is ignored.
- R7: After `last_xfer`, `cs_n` returns to 1 only once every bit of the final beat has been sent. A `last_xfer` with no frame open has no effect.
- R8: `rd_req` never opens a frame or moves the serial lines. It is answered by `rd_reject` = 1 in the following cycle only.
- R9: `sio_en` is never 1 while `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: open a write frame |
| frame_instr | input | 8 | Instruction code for the frame |
| frame_addr | input | ADDR_W | Start address (indirect address register value) |
| frame_addr_en | input | 1 | Frame carries an address phase |
| width_mode | input | 3 | Bus width setting; 3, 4, 5 are octal |
| ddr_en | input | 1 | Double data rate enable |
| txd_wr | input | 1 | Pulse: write to the transmit data register |
| txd_data | input | 16 | Transmit data value |
| last_xfer | input | 1 | Pulse: last-transfer command, closes the frame |
| rd_req | input | 1 | Read request, illegal in this mode |
| tx_empty | output | 1 | Holding register can take a new value |
| rd_reject | output | 1 | One-cycle reply to a read request |
| cs_n | output | 1 | Chip select, active low |
| sio_en | output | 1 | Serial lines carry valid bits this cycle |
| sio | output | LANES | Serial data bits |

## Verification
The bench compares every serial bit against a scoreboard for frames with and without an address. It covers byte beats, halfword beats, and an octal setting with DDR off, which must still send bytes. A design that ignored the DDR qualifier or sent the wrong half of `txd_data` would put mismatching bits on `sio`. Several other cases are probed directly:
- A write into a full holding register during the instruction phase, which a design without a full check would let overwrite pending data.
- Writes, last commands and read requests while idle, any of which a loose design would turn into activity on the serial lines.
- A second start inside an open frame, which must not send the address again.
- A long gap between beats, during which chip select must not drop.
- The close itself, where releasing chip select early would leave scoreboard entries unsent.

// File: rtl/smw_pkg.sv
package smw_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_ADDR = 2'd2,
      PH_DATA = 2'd3
   } phase_e;

   localparam int unsigned INSTR_BITS = 8;
   localparam int unsigned BYTE_BITS  = 8;
   localparam int unsigned HALF_BITS  = 16;

   localparam logic [2:0] WM_OCT_OUT = 3'd3;
   localparam logic [2:0] WM_OCT_IO  = 3'd4;
   localparam logic [2:0] WM_OCT_CMD = 3'd5;

   function automatic logic beat_is_half(input logic [2:0] mode, input logic ddr);
      return ddr && ((mode == WM_OCT_OUT) || (mode == WM_OCT_IO) || (mode == WM_OCT_CMD));
   endfunction

endpackage

// File: rtl/smw_shifter.sv
module smw_shifter #(
   parameter int unsigned SHW   = 24,
   parameter int unsigned LANES = 1,
   localparam int unsigned CW   = $clog2(SHW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [SHW-1:0]   ld_data,
   input  logic [CW-1:0]    ld_bits,
   output logic             busy,
   output logic             last,
   output logic [LANES-1:0] sio
);

   logic [SHW-1:0] sh_q;
   logic [CW-1:0]  cnt_q;

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CW'(LANES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (ld) begin
         sh_q  <= ld_data;
         cnt_q <= ld_bits;
      end else if (busy) begin
         sh_q  <= sh_q << LANES;
         cnt_q <= cnt_q - CW'(LANES);
      end
   end

   generate
      if (LANES == 1) begin : g_single
         assign sio = sh_q[SHW-1];
      end else begin : g_multi
         assign sio = sh_q[SHW-1 -: LANES];
      end
   endgenerate

   // R2: a new word may only enter while the shifter is idle or on its last group
   p_load_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (!busy || last));

   // R4: bit count always stays a whole number of lane groups
   p_cnt_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q % CW'(LANES)) == '0);

endmodule

// File: rtl/smw_hold.sv
module smw_hold #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic          valid,
   output logic [DW-1:0] dout
);

   logic accept;

   assign accept = push_req && (!valid || pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         if (accept) begin
            valid <= 1'b1;
            dout  <= din;
         end else if (pop) begin
            valid <= 1'b0;
         end
      end
   end

   // R5: a full holding register keeps its value until the shifter takes it
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop) |=> (valid && $stable(dout)));

   // R5: only a stored value can be taken
   p_pop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> valid);

endmodule

// File: rtl/smw_seq.sv
module smw_seq
   import smw_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SHW    = 24,
   localparam int unsigned CW    = $clog2(SHW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        instr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_en,
   input  logic              half_in,
   input  logic              last_req,
   input  logic              hold_valid,
   input  logic [15:0]       hold_data,
   input  logic              sh_busy,
   input  logic              sh_last,
   output logic              ld,
   output logic [SHW-1:0]    ld_data,
   output logic [CW-1:0]     ld_bits,
   output logic              pop,
   output logic              cs_n,
   output logic              accept_wr
);

   phase_e            phase_q, phase_d;
   logic              cs_n_d;
   logic              half_q, addr_en_q;
   logic [ADDR_W-1:0] addr_q;
   logic              close_q;
   logic              free;

   assign free      = !sh_busy || sh_last;
   assign accept_wr = (phase_q != PH_IDLE) && !close_q;

   always_comb begin
      phase_d = phase_q;
      cs_n_d  = cs_n;
      ld      = 1'b0;
      ld_data = '0;
      ld_bits = '0;
      pop     = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               ld      = 1'b1;
               ld_data = SHW'(instr) << (SHW - INSTR_BITS);
               ld_bits = CW'(INSTR_BITS);
               cs_n_d  = 1'b0;
               phase_d = PH_CMD;
            end
         end
         PH_CMD: begin
            if (free) begin
               if (addr_en_q) begin
                  ld      = 1'b1;
                  ld_data = SHW'(addr_q) << (SHW - ADDR_W);
                  ld_bits = CW'(ADDR_W);
                  phase_d = PH_ADDR;
               end else begin
                  phase_d = PH_DATA;
               end
            end
         end
         PH_ADDR: begin
            if (free) phase_d = PH_DATA;
         end
         PH_DATA: begin
            if (hold_valid && free) begin
               ld  = 1'b1;
               pop = 1'b1;
               if (half_q) begin
                  ld_data = SHW'(hold_data) << (SHW - HALF_BITS);
                  ld_bits = CW'(HALF_BITS);
               end else begin
                  ld_data = SHW'(hold_data[7:0]) << (SHW - BYTE_BITS);
                  ld_bits = CW'(BYTE_BITS);
               end
            end else if (close_q && !hold_valid && !sh_busy) begin
               cs_n_d  = 1'b1;
               phase_d = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cs_n      <= 1'b1;
         half_q    <= 1'b0;
         addr_en_q <= 1'b0;
         addr_q    <= '0;
         close_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cs_n    <= cs_n_d;
         if (phase_q == PH_IDLE && start) begin
            half_q    <= half_in;
            addr_en_q <= addr_en;
            addr_q    <= addr;
         end
         if (phase_d == PH_IDLE) close_q <= 1'b0;
         else if (last_req && phase_q != PH_IDLE) close_q <= 1'b1;
      end
   end

   // R7: chip select is released only after a close was requested and all data drained
   p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> ($past(close_q) && !$past(hold_valid) && !$past(sh_busy)));

   // R6: chip select cannot drop while data is still pending in the frame
   p_cs_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !close_q) |=> !cs_n);

   // R6: an open frame stays in a non-idle phase whatever start does
   p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && start && !close_q) |=> (phase_q == PH_DATA));

endmodule

// File: rtl/smw_writer.sv
module smw_writer
   import smw_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned LANES  = 1,
   localparam int unsigned SHW   = (ADDR_W > HALF_BITS) ? ADDR_W : HALF_BITS,
   localparam int unsigned CW    = $clog2(SHW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [7:0]        frame_instr,
   input  logic [ADDR_W-1:0] frame_addr,
   input  logic              frame_addr_en,
   input  logic [2:0]        width_mode,
   input  logic              ddr_en,
   input  logic              txd_wr,
   input  logic [15:0]       txd_data,
   input  logic              last_xfer,
   input  logic              rd_req,
   output logic              tx_empty,
   output logic              rd_reject,
   output logic              cs_n,
   output logic              sio_en,
   output logic [LANES-1:0]  sio
);

   generate
      if (!(LANES == 1 || LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
         $error("smw_writer: LANES must be 1, 2, 4 or 8");
      end
      if ((ADDR_W % 8) != 0 || ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
         $error("smw_writer: ADDR_W must be a byte multiple between 16 and 32");
      end
   endgenerate

   logic           ld, pop, accept_wr;
   logic [SHW-1:0] ld_data;
   logic [CW-1:0]  ld_bits;
   logic           sh_busy, sh_last;
   logic           hold_valid;
   logic [15:0]    hold_data;

   smw_seq #(.ADDR_W(ADDR_W), .SHW(SHW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (frame_start),
      .instr      (frame_instr),
      .addr       (frame_addr),
      .addr_en    (frame_addr_en),
      .half_in    (beat_is_half(width_mode, ddr_en)),
      .last_req   (last_xfer),
      .hold_valid (hold_valid),
      .hold_data  (hold_data),
      .sh_busy    (sh_busy),
      .sh_last    (sh_last),
      .ld         (ld),
      .ld_data    (ld_data),
      .ld_bits    (ld_bits),
      .pop        (pop),
      .cs_n       (cs_n),
      .accept_wr  (accept_wr)
   );

   smw_hold #(.DW(16)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (txd_wr && accept_wr),
      .pop      (pop),
      .din      (txd_data),
      .valid    (hold_valid),
      .dout     (hold_data)
   );

   smw_shifter #(.SHW(SHW), .LANES(LANES)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld),
      .ld_data (ld_data),
      .ld_bits (ld_bits),
      .busy    (sh_busy),
      .last    (sh_last),
      .sio     (sio)
   );

   assign sio_en   = sh_busy;
   assign tx_empty = !hold_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_reject <= 1'b0;
      else        rd_reject <= rd_req;
   end

   // R9: serial bits only inside a selected frame
   p_sio_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sio_en |-> !cs_n);

   // R5: the empty flag only falls because of a data write
   p_empty_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(txd_wr));

   // R8: a read request alone never opens a frame
   p_rd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cs_n && !frame_start) |=> cs_n);

endmodule

// File: tb/smw_writer_test.sv
module smw_writer_test;

   localparam int ADDR_W = 24;
   localparam int LANES  = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_start = 1'b0;
   logic [7:0]        frame_instr = '0;
   logic [ADDR_W-1:0] frame_addr = '0;
   logic              frame_addr_en = 1'b0;
   logic [2:0]        width_mode = '0;
   logic              ddr_en = 1'b0;
   logic              txd_wr = 1'b0;
   logic [15:0]       txd_data = '0;
   logic              last_xfer = 1'b0;
   logic              rd_req = 1'b0;
   logic              tx_empty, rd_reject, cs_n, sio_en;
   logic [LANES-1:0]  sio;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic exp_q[$];

   smw_writer #(.ADDR_W(ADDR_W), .LANES(LANES)) uut (.*);

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) exp_q.push_back(v[i]);
   endtask

   // monitor: compare every serial bit with the scoreboard
   always @(negedge clk) begin
      if (rst_n && sio_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4", int'(sio[0]), 0);
         end else begin
            logic e;
            e = exp_q.pop_front();
            check(sio[0] == e, "R2/R3/R4 serial bit", int'(sio[0]), int'(e));
         end
         check(!cs_n, "R9", int'(cs_n), 0);
      end
   end

   task automatic do_start(input logic [7:0] ins, input logic [ADDR_W-1:0] a,
                           input bit aen, input logic [2:0] wm, input bit ddr);
      @(negedge clk);
      frame_instr = ins; frame_addr = a; frame_addr_en = aen;
      width_mode = wm; ddr_en = ddr; frame_start = 1'b1;
      push_bits(32'(ins), 8);
      if (aen) push_bits(32'(a), ADDR_W);
      @(negedge clk);
      frame_start = 1'b0;
      check(!cs_n, "R2 cs low after start", int'(cs_n), 0);
   endtask

   task automatic do_write(input logic [15:0] d, input bit half);
      @(negedge clk);
      while (!tx_empty) @(negedge clk);
      txd_wr = 1'b1; txd_data = d;
      if (half) push_bits(32'(d), 16);
      else      push_bits(32'(d[7:0]), 8);
      @(negedge clk);
      txd_wr = 1'b0;
   endtask

   task automatic do_last();
      int t;
      @(negedge clk);
      last_xfer = 1'b1;
      @(negedge clk);
      last_xfer = 1'b0;
      t = 0;
      while (cs_n == 1'b0 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(cs_n == 1'b1, "R7 frame closed", int'(cs_n), 1);
      check(exp_q.size() == 0, "R7 all bits sent before cs release", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1 && sio_en == 1'b0 && tx_empty == 1'b1 && rd_reject == 1'b0,
            "R1 reset state", {cs_n, sio_en, tx_empty, rd_reject}, 4'b1010);
      rst_n = 1'b1;
      @(negedge clk);

      // byte beats with address; quad DDR is not octal, so bytes
      do_start(8'h32, 24'h123456, 1'b1, 3'd2, 1'b1);
      do_write(16'hFFA5, 1'b0);
      do_write(16'h003C, 1'b0);
      do_last();

      // octal DDR halfwords, no address phase (R3 absence, R4 halfword)
      do_start(8'h12, 24'hABCDEF, 1'b0, 3'd4, 1'b1);
      do_write(16'hBEEF, 1'b1);
      do_write(16'h0102, 1'b1);
      do_last();

      // octal without DDR gives bytes; also mode 5 with DDR gives halfword
      do_start(8'hC3, 24'h000001, 1'b1, 3'd3, 1'b0);
      do_write(16'h5A81, 1'b0);
      do_last();
      do_start(8'h0F, 24'hFFFFFF, 1'b1, 3'd5, 1'b1);
      do_write(16'h8001, 1'b1);
      do_last();

      // R5: hold full during instruction phase, second write dropped
      @(negedge clk);
      frame_instr = 8'hA0; frame_addr_en = 1'b0; width_mode = 3'd0; ddr_en = 1'b0;
      frame_start = 1'b1;
      push_bits(32'h0A0, 8);
      @(negedge clk);
      frame_start = 1'b0;
      txd_wr = 1'b1; txd_data = 16'h0077;
      push_bits(32'h77, 8);
      @(negedge clk);
      check(tx_empty == 1'b0, "R5 empty low while held", int'(tx_empty), 0);
      txd_data = 16'h0011;
      @(negedge clk);
      txd_wr = 1'b0;
      check(tx_empty == 1'b0, "R5 held value kept", int'(tx_empty), 0);
      // R6: second start during open frame is ignored
      frame_start = 1'b1; frame_instr = 8'hEE;
      @(negedge clk);
      frame_start = 1'b0;
      repeat (60) @(negedge clk);
      check(cs_n == 1'b0, "R6 cs held over gap", int'(cs_n), 0);
      check(tx_empty == 1'b1, "R5 empty after take", int'(tx_empty), 1);
      do_write(16'h00C9, 1'b0);
      do_last();

      // R5 idle write, R7 idle last, R8 read request
      @(negedge clk);
      txd_wr = 1'b1; txd_data = 16'h1234;
      @(negedge clk);
      txd_wr = 1'b0;
      check(tx_empty == 1'b1, "R5 idle write dropped", int'(tx_empty), 1);
      last_xfer = 1'b1;
      @(negedge clk);
      last_xfer = 1'b0;
      check(cs_n == 1'b1, "R7 idle last no effect", int'(cs_n), 1);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      check(rd_reject == 1'b1, "R8 reject pulse", int'(rd_reject), 1);
      check(cs_n == 1'b1 && sio_en == 1'b0, "R8 no frame", {cs_n, sio_en}, 2'b10);
      @(negedge clk);
      check(rd_reject == 1'b0, "R8 reject one cycle", int'(rd_reject), 0);
      repeat (20) @(negedge clk);
      check(cs_n == 1'b1, "R8 still idle", int'(cs_n), 1);
      check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) check(1'b0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule